// File: doc/BRIEF.md
# Burst Offset Generator

This block supplies the low-order address bits for a four-beat burst into a synchronous memory. When either address strobe is accepted, it takes a starting offset from the low address bits. On each later advance pulse it moves to the next beat of the burst. The full address seen by the array is the registered upper address with this offset appended.

A static order input picks one of two sequences. The interleaved sequence is the starting offset XOR a hidden beat index. The linear sequence adds one modulo four on each step. Inside, the block keeps the starting offset and a beat index that clears on every load. A library parameter can build only one of the two orders, which removes the selection logic. Loads take priority over advances. The processor strobe has no effect at all while chip select is inactive. A controller strobe seen while chip select is inactive deselects the device and freezes the offset for that cycle.

Top module: `burst_ofs_gen`

## Requirements
- R1: A synchronous active-high `rst` makes `beat_ofs` read 0 in the cycle after the reset edge, whatever happens on the other inputs in that cycle.
- R2: When `chip_sel` is 1 and either `cpu_strobe` or `ctl_strobe` is 1 at a clock edge, `beat_ofs` equals the `start_ofs` sampled at that edge from the next cycle on.
- R3: With `lin_order` = 0 (interleaved), the k-th advance after a load gives start XOR k: start 00 gives 00,01,10,11; 01 gives 01,00,11,10; 10 gives 10,11,00,01; 11 gives 11,10,01,00.
- R4: With `lin_order` = 1 (linear), each advance adds one modulo 4 to `beat_ofs`, so start 10 gives 10,11,00,01.
- R5: In an edge where a strobe is accepted together with `chip_sel`, `advance` is ignored and the counter loads `start_ofs` instead.
- R6: In an edge with no accepted load and no `advance`, `beat_ofs` keeps its value.
- R7: While `chip_sel` is 0, `cpu_strobe` neither loads the counter nor blocks an advance: `advance` = 1 still steps the offset.
- R8: While `chip_sel` is 0, `ctl_strobe` = 1 deselects the device. In that edge the offset holds, and both the load and any `advance` are dropped.
- R9: The fourth advance after a load returns `beat_ofs` to the starting offset in both orders, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Chip select, active high |
| cpu_strobe | input | 1 | Processor address strobe, active high |
| ctl_strobe | input | 1 | Controller address strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| lin_order | input | 1 | Burst order: 0 = interleaved, 1 = linear (static) |
| start_ofs | input | OFS_W | Low address bits captured on a load |
| beat_ofs | output | OFS_W | Current burst offset |

## Verification
Every control input is sampled at a rising edge, and only two registers lie on the path, so each load, step, hold or reset appears on `beat_ofs` one cycle after the edge that sampled it. `beat_ofs` is a combinational function of those registers and the order input. The bench therefore drives inputs at the falling edge. It waits for the next rising edge and samples 1 ns later, well before the following edge. Each scenario task compares the offset with a value worked out from the burst-order rules after every single edge, so a step that comes a cycle late or early shows up at once.

// File: rtl/bog_pkg.sv
package bog_pkg;
   // Which burst orders the block is built with
   typedef enum logic [1:0] {
      ORD_BOTH     = 2'd0,
      ORD_XOR_ONLY = 2'd1,
      ORD_LIN_ONLY = 2'd2
   } order_support_e;

   // Decoded per-edge control
   typedef struct packed {
      logic load;
      logic step;
   } bog_ctl_t;
endpackage

// File: rtl/bog_ctl.sv
module bog_ctl
   import bog_pkg::*;
(
   input  logic     chip_sel,
   input  logic     cpu_strobe,
   input  logic     ctl_strobe,
   input  logic     advance,
   output bog_ctl_t ctl
);
   logic any_strobe;
   logic deselect;

   always_comb begin
      any_strobe = cpu_strobe | ctl_strobe;
      // processor strobe only counts while selected
      ctl.load   = chip_sel & any_strobe;
      // controller strobe without select freezes the counter
      deselect   = ~chip_sel & ctl_strobe;
      ctl.step   = advance & ~ctl.load & ~deselect;
   end
endmodule

// File: rtl/bog_state.sv
module bog_state
   import bog_pkg::*;
#(
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  bog_ctl_t         ctl,
   input  logic [OFS_W-1:0] start_ofs,
   output logic [OFS_W-1:0] base_q,
   output logic [OFS_W-1:0] idx_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (ctl.load) begin
         base_q <= start_ofs;
         idx_q  <= '0;
      end else if (ctl.step) begin
         idx_q  <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/bog_map.sv
module bog_map
   import bog_pkg::*;
#(
   parameter int             OFS_W = 2,
   parameter order_support_e ORDER = ORD_BOTH
) (
   input  logic             lin_order,
   input  logic [OFS_W-1:0] base_q,
   input  logic [OFS_W-1:0] idx_q,
   output logic [OFS_W-1:0] beat_ofs
);
   logic [OFS_W-1:0] xor_ofs;
   logic [OFS_W-1:0] lin_ofs;

   assign xor_ofs = base_q ^ idx_q;
   assign lin_ofs = base_q + idx_q;

   generate
      if (ORDER == ORD_XOR_ONLY) begin : g_xor
         logic unused_sel;
         assign unused_sel = lin_order ^ (^lin_ofs);
         assign beat_ofs   = xor_ofs;
      end else if (ORDER == ORD_LIN_ONLY) begin : g_lin
         logic unused_sel;
         assign unused_sel = lin_order ^ (^xor_ofs);
         assign beat_ofs   = lin_ofs;
      end else begin : g_both
         assign beat_ofs = lin_order ? lin_ofs : xor_ofs;
      end
   endgenerate
endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
   import bog_pkg::*;
#(
   parameter int             OFS_W = 2,
   parameter order_support_e ORDER = ORD_BOTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chip_sel,
   input  logic             cpu_strobe,
   input  logic             ctl_strobe,
   input  logic             advance,
   input  logic             lin_order,
   input  logic [OFS_W-1:0] start_ofs,
   output logic [OFS_W-1:0] beat_ofs
);
   localparam int BEATS = 1 << OFS_W;

   generate
      if (OFS_W < 1 || OFS_W > 8) begin : g_bad_w
         $error("burst_ofs_gen: OFS_W must be 1..8");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("burst_ofs_gen: at least two beats needed");
      end
   endgenerate

   bog_ctl_t         ctl;
   logic [OFS_W-1:0] base_q;
   logic [OFS_W-1:0] idx_q;

   bog_ctl i_ctl (
      .chip_sel  (chip_sel),
      .cpu_strobe(cpu_strobe),
      .ctl_strobe(ctl_strobe),
      .advance   (advance),
      .ctl       (ctl)
   );

   bog_state #(.OFS_W(OFS_W)) i_state (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl),
      .start_ofs(start_ofs),
      .base_q   (base_q),
      .idx_q    (idx_q)
   );

   bog_map #(.OFS_W(OFS_W), .ORDER(ORDER)) i_map (
      .lin_order(lin_order),
      .base_q   (base_q),
      .idx_q    (idx_q),
      .beat_ofs (beat_ofs)
   );

   // ---------------- assertions ----------------
   logic lin_eff;
   logic xor_eff;
   logic acc_load;
   logic free_step;
   assign lin_eff   = (ORDER == ORD_LIN_ONLY) || (ORDER == ORD_BOTH && lin_order);
   assign xor_eff   = (ORDER == ORD_XOR_ONLY) || (ORDER == ORD_BOTH && !lin_order);
   assign acc_load  = chip_sel && (cpu_strobe || ctl_strobe);
   assign free_step = advance && !acc_load && !ctl_strobe;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> beat_ofs == '0);

   p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
      acc_load |=> beat_ofs == $past(start_ofs));

   p_xor_moves_r3: assert property (@(posedge clk) disable iff (rst)
      (free_step && xor_eff) |=> (!xor_eff || beat_ofs != $past(beat_ofs)));

   p_lin_step_r4: assert property (@(posedge clk) disable iff (rst)
      (free_step && lin_eff) |=>
         (!lin_eff || beat_ofs == OFS_W'($past(beat_ofs) + 1'b1)));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!advance && !acc_load) |=> (!$stable(lin_order) || $stable(beat_ofs)));

   p_desel_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!chip_sel && ctl_strobe) |=> (!$stable(lin_order) || $stable(beat_ofs)));
endmodule

// File: tb/test_burst_ofs_gen.sv
module test_burst_ofs_gen;
   logic       clk = 1'b0;
   logic       rst;
   logic       chip_sel;
   logic       cpu_strobe;
   logic       ctl_strobe;
   logic       advance;
   logic       lin_order;
   logic [1:0] start_ofs;
   logic [1:0] beat_ofs;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   burst_ofs_gen i_burst_ofs_gen (
      .clk       (clk),
      .rst       (rst),
      .chip_sel  (chip_sel),
      .cpu_strobe(cpu_strobe),
      .ctl_strobe(ctl_strobe),
      .advance   (advance),
      .lin_order (lin_order),
      .start_ofs (start_ofs),
      .beat_ofs  (beat_ofs)
   );

   // drive at falling edge, sample 1 ns after the next rising edge
   task automatic cyc(input logic cs, input logic cp, input logic ct,
                      input logic adv, input logic [1:0] so);
      @(negedge clk);
      chip_sel   = cs;
      cpu_strobe = cp;
      ctl_strobe = ct;
      advance    = adv;
      start_ofs  = so;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [1:0] exp);
      n_chk++;
      if (beat_ofs !== exp) begin
         n_fail++;
         $display("FAIL %s: beat_ofs=%b expected=%b", req, beat_ofs, exp);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11);
      check("R1 reset", 2'b00);
      rst = 1'b0;
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      check("R1 after reset", 2'b00);
   endtask

   task automatic t_order(input logic lin);
      lin_order = lin;
      for (int s = 0; s < 4; s++) begin
         cyc(1'b1, s[0], ~s[0], 1'b0, 2'(s));
         check("R2 load", 2'(s));
         for (int k = 1; k < 4; k++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
            if (lin) check("R4 linear beat", 2'(s + k));
            else     check("R3 interleaved beat", 2'(s ^ k));
         end
         cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
         check("R9 wrap", 2'(s));
      end
   endtask

   task automatic t_load_priority;
      lin_order = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b01);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
      check("R4 step", 2'b10);
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b10);
      check("R5 load over advance (cpu)", 2'b10);
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11);
      check("R5 load over advance (ctl)", 2'b11);
      lin_order = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
      check("R5 index restarted", 2'b10);
   endtask

   task automatic t_hold;
      lin_order = 1'b0;
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b01);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b11);
      check("R3 step", 2'b00);
      for (int i = 0; i < 3; i++) begin
         cyc(i[0], 1'b0, 1'b0, 1'b0, 2'b10);
         check("R6 hold", 2'b00);
      end
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b10);
      check("R3 resume", 2'b11);
   endtask

   task automatic t_cpu_desel;
      lin_order = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11);
      check("R7 cpu strobe ignored", 2'b00);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11);
      check("R7 advance not blocked", 2'b01);
   endtask

   task automatic t_ctl_desel;
      lin_order = 1'b1;
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b10);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b01);
      check("R8 deselect holds", 2'b10);
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
      check("R8 deselect no load", 2'b10);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
      check("R8 after deselect", 2'b11);
   endtask

   task automatic t_reset_mid;
      lin_order = 1'b0;
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
      check("R3 mid burst", 2'b10);
      rst = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b01);
      check("R1 reset beats load", 2'b00);
      rst = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
      check("R1 index cleared", 2'b01);
   endtask

   initial begin
      rst = 1'b1; chip_sel = 1'b0; cpu_strobe = 1'b0; ctl_strobe = 1'b0;
      advance = 1'b0; lin_order = 1'b0; start_ofs = 2'b00;
      t_reset();
      t_order(1'b0);
      t_order(1'b1);
      t_load_priority();
      t_hold();
      t_cpu_desel();
      t_ctl_desel();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule